// File: doc/BRIEF.md
# Straight-Piece Clockwise Rotation Controller

This block turns a four-cell straight piece a quarter turn clockwise on an 8x8 playfield. The playfield is stored one bit per cell in an external memory that the block reaches through a single port. That port has a synchronous read with one cycle of latency and a synchronous write. The block keeps the piece's state: the pivot (third cell), the orientation code and the coordinates of the three moving cells. A load strobe places the piece. The load writes nothing to memory, so the caller draws the piece into the field.

On a rotate pulse the block first checks the pivot against limits that depend on the orientation. It then reads, one cell at a time, the three cells the moving cells will land on and four cells swept on the way. If the pivot fails or any probed cell is lit, the block gives a reject pulse and leaves memory untouched. Otherwise it clears the three moving cells, shifts their coordinates in one step, lights them at their new places, advances the orientation and gives a done pulse. The pivot cell is never written.

Coordinates are 3 bits with (0,0) at the top-left corner, x to the right and y downward. Orientation 00 is horizontal with p1, p2, pivot, p4 running left to right. Each successful turn adds one to the code, modulo 4.

Top module: `brick_spin_ctrl`

## Requirements
- R1: After reset, busy, done, reject and memWe are low and orient is 00.
- R2: loadEn while idle sets the pivot to (loadX, loadY) and the orientation to loadOrient, with no memory write. p1 sits at pivot+(-2,0), (0,-2), (2,0), (0,2) for orientations 00, 01, 10, 11. p2 sits at half that offset and p4 at the negated half.
- R3: Every memory access uses the address {2'b01, row[2:0], 1'b1, column[2:0]}.
- R4: A rotation goes ahead only when the pivot is inside the limits for its orientation: 00 row 2..6, 01 column 1..5, 10 row 1..5, 11 column 2..6. Outside them the block gives reject, writes nothing and keeps orient unchanged.
- R5: The three cells that p1, p2 and p4 will occupy are read first, each address held one cycle before its bit is sampled. Any lit one gives reject with no write.
- R6: Four swept cells are then read. In orientation 00 they lie at pivot+(-2,-1), (-1,-1), (-1,-2) and (1,1), and they turn with the piece. Any lit one gives reject with no write.
- R7: Lit cells outside the probed set have no effect on the rotation and are never written.
- R8: A rotation that goes ahead makes exactly six writes: data 0 to the old p1, p2, p4 in that order, then data 1 to the new p1, p2, p4 in that order. The pivot is never written.
- R9: A successful rotation adds one to orient modulo 4, and four rotations restore the original layout.
- R10: done and reject are single-cycle pulses that never occur together. done follows the last write by one cycle.
- R11: rotReq and loadEn are ignored while busy. When both arrive in the same idle cycle, the load is taken and the rotate is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadEn | input | 1 | Place-piece strobe, taken only when idle |
| loadX | input | 3 | Pivot column for a load |
| loadY | input | 3 | Pivot row for a load |
| loadOrient | input | 2 | Orientation code for a load |
| rotReq | input | 1 | Single-cycle clockwise rotate request |
| rdBit | input | 1 | Memory read data, one cycle after the address |
| memAddr | output | 9 | Memory address |
| memWe | output | 1 | Memory write enable |
| memWdata | output | 1 | Memory write data |
| busy | output | 1 | High while a rotation sequence runs |
| done | output | 1 | Pulse: rotation committed |
| reject | output | 1 | Pulse: rotation refused |
| orient | output | 2 | Current orientation code |

## Verification
The hardest case to reach is an abort caused by one particular probe, for example the swept cell two rows above the pivot's left neighbour. A wrong offset there still rotates correctly on an empty field. The bench owns the playfield model, so it lights exactly one chosen cell next to an otherwise legal piece. It then checks for reject and for an unchanged field, in two orientations. It also lights cells just outside the probed set and requires a normal commit, so offsets that drift onto neighbouring cells get caught.

// File: rtl/spin_pkg.sv
package spin_pkg;
  localparam int NPROBE = 7;
  localparam int NCELL  = 3;

  typedef enum logic [3:0] {
    SEL_P1 = 4'd0, SEL_P2 = 4'd1, SEL_P4 = 4'd2,
    SEL_V1 = 4'd3, SEL_V2 = 4'd4, SEL_V3 = 4'd5,
    SEL_O1 = 4'd6, SEL_O2 = 4'd7, SEL_O3 = 4'd8, SEL_O4 = 4'd9
  } selT;

  typedef struct packed {
    logic loadPiece;
    logic advance;
    logic we;
    logic wdata;
    selT  sel;
  } spinStrobeT;

  typedef struct packed {
    logic signed [3:0] dx;
    logic signed [3:0] dy;
  } offT;

  // quarter turn clockwise on a y-down grid: (dx,dy) -> (-dy,dx)
  function automatic offT rotCw(offT a, logic [1:0] k);
    offT r;
    r = a;
    for (int i = 0; i < 3; i++) begin
      if (i < int'(k)) r = '{dx: -r.dy, dy: r.dx};
    end
    return r;
  endfunction

  // probe offsets from the pivot, orientation 00 frame
  function automatic offT probeBase(selT s);
    case (s)
      SEL_V1:  return '{dx: 4'sd0,  dy: -4'sd2};
      SEL_V2:  return '{dx: 4'sd0,  dy: -4'sd1};
      SEL_V3:  return '{dx: 4'sd0,  dy: 4'sd1};
      SEL_O1:  return '{dx: -4'sd2, dy: -4'sd1};
      SEL_O2:  return '{dx: -4'sd1, dy: -4'sd1};
      SEL_O3:  return '{dx: -4'sd1, dy: -4'sd2};
      SEL_O4:  return '{dx: 4'sd1,  dy: 4'sd1};
      default: return '{dx: 4'sd0,  dy: 4'sd0};
    endcase
  endfunction

  // moving-cell offsets from the pivot, orientation 00 frame
  function automatic offT cellBase(int i);
    case (i)
      0:       return '{dx: -4'sd2, dy: 4'sd0};
      1:       return '{dx: -4'sd1, dy: 4'sd0};
      default: return '{dx: 4'sd1,  dy: 4'sd0};
    endcase
  endfunction

  // per-turn displacement of each moving cell, orientation 00 frame
  function automatic offT moveBase(int i);
    case (i)
      0:       return '{dx: 4'sd2,  dy: -4'sd2};
      1:       return '{dx: 4'sd1,  dy: -4'sd1};
      default: return '{dx: -4'sd1, dy: 4'sd1};
    endcase
  endfunction
endpackage

// File: rtl/brick_spin_path.sv
module brick_spin_path
  import spin_pkg::*;
#(
  parameter  int COORD_W = 3,
  localparam int ADDR_W  = 2 * COORD_W + 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  spinStrobeT         strb,
  input  logic [COORD_W-1:0] loadX,
  input  logic [COORD_W-1:0] loadY,
  input  logic [1:0]         loadOrient,
  output logic [ADDR_W-1:0]  memAddr,
  output logic               boundOk,
  output logic [1:0]         orient
);
  localparam int GRID_MAX = (1 << COORD_W) - 1;
  localparam logic [COORD_W-1:0] LIM_1  = COORD_W'(1);
  localparam logic [COORD_W-1:0] LIM_2  = COORD_W'(2);
  localparam logic [COORD_W-1:0] LIM_H1 = COORD_W'(GRID_MAX - 1);
  localparam logic [COORD_W-1:0] LIM_H2 = COORD_W'(GRID_MAX - 2);
  localparam logic [COORD_W-1:0] RST_PIV = COORD_W'(2);

  function automatic logic [COORD_W-1:0] addOff(logic [COORD_W-1:0] c, logic signed [3:0] d);
    return c + COORD_W'(d);
  endfunction

  logic [COORD_W-1:0] pivX, pivY;
  logic [COORD_W-1:0] cellX [NCELL];
  logic [COORD_W-1:0] cellY [NCELL];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pivX   <= RST_PIV;
      pivY   <= '0;
      orient <= 2'b00;
    end else if (strb.loadPiece) begin
      pivX   <= loadX;
      pivY   <= loadY;
      orient <= loadOrient;
    end else if (strb.advance) begin
      orient <= orient + 2'd1;
    end
  end

  for (genvar g = 0; g < NCELL; g++) begin : g_cell
    offT loadOff, stepOff;
    always_comb begin
      loadOff = rotCw(cellBase(g), loadOrient);
      stepOff = rotCw(moveBase(g), orient);
    end
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cellX[g] <= addOff(RST_PIV, cellBase(g).dx);
        cellY[g] <= addOff('0, cellBase(g).dy);
      end else if (strb.loadPiece) begin
        cellX[g] <= addOff(loadX, loadOff.dx);
        cellY[g] <= addOff(loadY, loadOff.dy);
      end else if (strb.advance) begin
        cellX[g] <= addOff(cellX[g], stepOff.dx);
        cellY[g] <= addOff(cellY[g], stepOff.dy);
      end
    end
  end

  offT probeOff;
  logic [COORD_W-1:0] selX, selY;

  always_comb begin
    probeOff = rotCw(probeBase(strb.sel), orient);
    case (strb.sel)
      SEL_P1:  begin selX = cellX[0]; selY = cellY[0]; end
      SEL_P2:  begin selX = cellX[1]; selY = cellY[1]; end
      SEL_P4:  begin selX = cellX[2]; selY = cellY[2]; end
      default: begin
        selX = addOff(pivX, probeOff.dx);
        selY = addOff(pivY, probeOff.dy);
      end
    endcase
  end

  assign memAddr = {2'b01, selY, 1'b1, selX};

  always_comb begin
    case (orient)
      2'b00:   boundOk = (pivY >= LIM_2) && (pivY <= LIM_H1);
      2'b01:   boundOk = (pivX >= LIM_1) && (pivX <= LIM_H2);
      2'b10:   boundOk = (pivY >= LIM_1) && (pivY <= LIM_H2);
      default: boundOk = (pivX >= LIM_2) && (pivX <= LIM_H1);
    endcase
  end
endmodule

// File: rtl/brick_spin_fsm.sv
module brick_spin_fsm
  import spin_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadEn,
  input  logic       rotReq,
  input  logic       rdBit,
  input  logic       boundOk,
  output spinStrobeT strb,
  output logic       busy,
  output logic       done,
  output logic       reject
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_BOUND, ST_PROBE, ST_CHECK, ST_ERASE, ST_MOVE, ST_DRAW
  } stT;

  localparam logic [2:0] LAST_PROBE = 3'(NPROBE - 1);
  localparam logic [2:0] LAST_CELL  = 3'(NCELL - 1);

  stT         state;
  logic [2:0] idx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      idx    <= '0;
      done   <= 1'b0;
      reject <= 1'b0;
    end else begin
      done   <= 1'b0;
      reject <= 1'b0;
      case (state)
        ST_IDLE:  if (!loadEn && rotReq) state <= ST_BOUND;
        ST_BOUND: begin
          idx <= '0;
          if (boundOk) state <= ST_PROBE;
          else begin state <= ST_IDLE; reject <= 1'b1; end
        end
        ST_PROBE: state <= ST_CHECK;
        ST_CHECK: begin
          if (rdBit) begin
            state  <= ST_IDLE;
            reject <= 1'b1;
          end else if (idx == LAST_PROBE) begin
            idx   <= '0;
            state <= ST_ERASE;
          end else begin
            idx   <= idx + 3'd1;
            state <= ST_PROBE;
          end
        end
        ST_ERASE: begin
          if (idx == LAST_CELL) begin idx <= '0; state <= ST_MOVE; end
          else idx <= idx + 3'd1;
        end
        ST_MOVE:  state <= ST_DRAW;
        ST_DRAW: begin
          if (idx == LAST_CELL) begin
            idx   <= '0;
            state <= ST_IDLE;
            done  <= 1'b1;
          end else idx <= idx + 3'd1;
        end
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.loadPiece = (state == ST_IDLE) && loadEn;
    strb.advance   = (state == ST_MOVE);
    strb.we        = (state == ST_ERASE) || (state == ST_DRAW);
    strb.wdata     = (state == ST_DRAW);
    if (state == ST_PROBE || state == ST_CHECK)
      strb.sel = selT'(4'(SEL_V1) + {1'b0, idx});
    else
      strb.sel = selT'({1'b0, idx});
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/brick_spin_ctrl.sv
module brick_spin_ctrl
  import spin_pkg::*;
#(
  parameter  int COORD_W = 3,
  localparam int ADDR_W  = 2 * COORD_W + 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadEn,
  input  logic [COORD_W-1:0] loadX,
  input  logic [COORD_W-1:0] loadY,
  input  logic [1:0]         loadOrient,
  input  logic               rotReq,
  input  logic               rdBit,
  output logic [ADDR_W-1:0]  memAddr,
  output logic               memWe,
  output logic               memWdata,
  output logic               busy,
  output logic               done,
  output logic               reject,
  output logic [1:0]         orient
);
  spinStrobeT strb;
  logic       boundOk;

  brick_spin_fsm u_fsm (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .rotReq(rotReq), .rdBit(rdBit),
    .boundOk(boundOk), .strb(strb), .busy(busy), .done(done), .reject(reject)
  );

  brick_spin_path #(.COORD_W(COORD_W)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .loadX(loadX), .loadY(loadY),
    .loadOrient(loadOrient), .memAddr(memAddr), .boundOk(boundOk), .orient(orient)
  );

  assign memWe    = strb.we;
  assign memWdata = strb.wdata;
endmodule

// File: rtl/brick_spin_checker.sv
module brick_spin_checker #(
  parameter  int COORD_W = 3,
  localparam int ADDR_W  = 2 * COORD_W + 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadEn,
  input logic              rotReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memWe,
  input logic              memWdata,
  input logic              busy,
  input logic              done,
  input logic              reject,
  input logic [1:0]        orient
);
  p_addr_fmt_r3: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memAddr[ADDR_W-1 -: 2] == 2'b01) && memAddr[COORD_W]);

  p_pulse_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(done && reject));

  p_done_after_draw_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(memWe) && $past(memWdata));

  p_write_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);

  p_reject_no_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    reject |-> !memWe && !$past(memWe));

  p_orient_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !loadEn && !rotReq) |=> $stable(orient));

  p_rot_start_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && rotReq && !loadEn) |=> busy);

  p_load_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && loadEn) |=> !busy);
endmodule

bind brick_spin_ctrl brick_spin_checker #(.COORD_W(COORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .loadEn(loadEn), .rotReq(rotReq), .memAddr(memAddr),
  .memWe(memWe), .memWdata(memWdata), .busy(busy), .done(done), .reject(reject),
  .orient(orient)
);

// File: tb/brick_spin_ctrl_tb.sv
module brick_spin_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadEn = 1'b0;
  logic [2:0] loadX = '0, loadY = '0;
  logic [1:0] loadOrient = '0;
  logic rotReq = 1'b0;
  logic rdBit;
  logic [8:0] memAddr;
  logic memWe, memWdata, busy, done, reject;
  logic [1:0] orient;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  brick_spin_ctrl u_dut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadX(loadX), .loadY(loadY),
    .loadOrient(loadOrient), .rotReq(rotReq), .rdBit(rdBit), .memAddr(memAddr),
    .memWe(memWe), .memWdata(memWdata), .busy(busy), .done(done), .reject(reject),
    .orient(orient)
  );

  // playfield model: synchronous read, one cycle latency
  logic field [8][8];
  logic expField [8][8];
  int wrCount = 0;
  int addrBad = 0;
  logic [8:0] wrAddr [16];
  logic wrData [16];

  always @(posedge clk) begin
    rdBit <= field[memAddr[6:4]][memAddr[2:0]];
    if (memWe) begin
      field[memAddr[6:4]][memAddr[2:0]] <= memWdata;
      if (memAddr[8:7] != 2'b01 || !memAddr[3]) addrBad++;
      if (wrCount < 16) begin
        wrAddr[wrCount] = memAddr;
        wrData[wrCount] = memWdata;
      end
      wrCount++;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [8:0] addrOf(input int x, input int y);
    return {2'b01, 3'(y), 1'b1, 3'(x)};
  endfunction

  // p1 offset from pivot per orientation; p2 is half, p4 minus half
  task automatic cellAt(input int px, input int py, input int k, input int which,
                        output int x, output int y);
    int ox, oy;
    case (k)
      0: begin ox = -2; oy = 0; end
      1: begin ox = 0; oy = -2; end
      2: begin ox = 2; oy = 0; end
      default: begin ox = 0; oy = 2; end
    endcase
    case (which)
      1: begin x = px + ox; y = py + oy; end
      2: begin x = px + ox / 2; y = py + oy / 2; end
      default: begin x = px - ox / 2; y = py - oy / 2; end
    endcase
  endtask

  task automatic clearAll();
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin field[i][j] = 1'b0; expField[i][j] = 1'b0; end
  endtask

  task automatic putPiece(input int px, input int py, input int k, input logic v);
    int x, y;
    field[py][px] = v; expField[py][px] = v;
    cellAt(px, py, k, 1, x, y); field[y][x] = v; expField[y][x] = v;
    cellAt(px, py, k, 2, x, y); field[y][x] = v; expField[y][x] = v;
    cellAt(px, py, k, 4, x, y); field[y][x] = v; expField[y][x] = v;
  endtask

  task automatic expPiece(input int px, input int py, input int k, input logic v);
    int x, y;
    expField[py][px] = v;
    cellAt(px, py, k, 1, x, y); expField[y][x] = v;
    cellAt(px, py, k, 2, x, y); expField[y][x] = v;
    cellAt(px, py, k, 4, x, y); expField[y][x] = v;
  endtask

  task automatic lightCell(input int x, input int y);
    field[y][x] = 1'b1; expField[y][x] = 1'b1;
  endtask

  task automatic chkField(input string req);
    int diff = 0;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) if (field[i][j] !== expField[i][j]) diff++;
    chk(req, diff, 0);
  endtask

  task automatic loadPiece(input int px, input int py, input int k);
    @(negedge clk);
    loadEn = 1'b1; loadX = 3'(px); loadY = 3'(py); loadOrient = 2'(k);
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  // result: 1 done, 2 reject, 0 timeout; counts the done/reject pulses seen
  task automatic rotate(output int result, output int pulses);
    int n = 0;
    result = 0; pulses = 0;
    wrCount = 0;
    @(negedge clk);
    rotReq = 1'b1;
    @(negedge clk);
    rotReq = 1'b0;
    while (n < 100) begin
      if (done && reject) pulses += 10;
      if (done) begin result = 1; pulses++; end
      if (reject) begin result = 2; pulses++; end
      if (result != 0) break;
      @(negedge clk); n++;
    end
    @(negedge clk);
    if (done || reject) pulses++;
  endtask

  task automatic testReset();
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 reject", int'(reject), 0);
    chk("R1 memWe", int'(memWe), 0);
    chk("R1 orient", int'(orient), 0);
  endtask

  task automatic testLoad();
    wrCount = 0;
    loadPiece(3, 5, 2);
    repeat (2) @(negedge clk);
    chk("R2 orient after load", int'(orient), 2);
    chk("R2 no write on load", wrCount, 0);
    chk("R2 idle after load", int'(busy), 0);
  endtask

  task automatic testBasic();
    int res, pl, x, y;
    clearAll(); putPiece(4, 4, 0, 1'b1);
    loadPiece(4, 4, 0);
    rotate(res, pl);
    chk("R8 rotation commits", res, 1);
    chk("R10 single pulse", pl, 1);
    chk("R8 write count", wrCount, 6);
    cellAt(4, 4, 0, 1, x, y); chk("R8 erase p1 addr", int'(wrAddr[0]), int'(addrOf(x, y)));
    chk("R8 erase data", int'(wrData[0]), 0);
    cellAt(4, 4, 0, 2, x, y); chk("R8 erase p2 addr", int'(wrAddr[1]), int'(addrOf(x, y)));
    cellAt(4, 4, 0, 4, x, y); chk("R8 erase p4 addr", int'(wrAddr[2]), int'(addrOf(x, y)));
    cellAt(4, 4, 1, 1, x, y); chk("R8 draw p1 addr", int'(wrAddr[3]), int'(addrOf(x, y)));
    chk("R8 draw data", int'(wrData[3]), 1);
    cellAt(4, 4, 1, 2, x, y); chk("R8 draw p2 addr", int'(wrAddr[4]), int'(addrOf(x, y)));
    cellAt(4, 4, 1, 4, x, y); chk("R8 draw p4 addr", int'(wrAddr[5]), int'(addrOf(x, y)));
    chk("R8 erase then draw", int'(wrData[2]) * 2 + int'(wrData[5]), 1);
    expPiece(4, 4, 0, 1'b0); expPiece(4, 4, 1, 1'b1);
    chkField("R8 field after turn");
    chk("R9 orient advanced", int'(orient), 1);
    chk("R3 address format", addrBad, 0);
  endtask

  task automatic testFullCycle();
    int res, pl;
    for (int k = 1; k < 4; k++) begin
      rotate(res, pl);
      chk("R9 successive turn", res, 1);
    end
    clearAll(); putPiece(4, 4, 0, 1'b1);
    field[4][4] = 1'b1;
    chk("R9 orient wraps", int'(orient), 0);
  endtask

  task automatic fullCycleField();
    int res, pl;
    clearAll(); putPiece(4, 4, 0, 1'b1);
    loadPiece(4, 4, 0);
    for (int k = 0; k < 4; k++) rotate(res, pl);
    chkField("R9 layout restored");
    chk("R9 orient back to 00", int'(orient), 0);
  endtask

  task automatic boundCase(input int px, input int py, input int k, input int expRes, input string req);
    int res, pl;
    clearAll(); putPiece(px, py, k, 1'b1);
    loadPiece(px, py, k);
    rotate(res, pl);
    chk(req, res, expRes);
    if (expRes == 2) begin
      chk({req, " no write"}, wrCount, 0);
      chk({req, " orient kept"}, int'(orient), k);
      chkField({req, " field kept"});
    end else begin
      chk({req, " orient"}, int'(orient), (k + 1) % 4);
    end
  endtask

  task automatic testBounds();
    boundCase(4, 1, 0, 2, "R4 o00 row1");
    boundCase(4, 7, 0, 2, "R4 o00 row7");
    boundCase(4, 6, 0, 1, "R4 o00 row6");
    boundCase(0, 4, 1, 2, "R4 o01 col0");
    boundCase(3, 6, 2, 2, "R4 o10 row6");
    boundCase(7, 3, 3, 2, "R4 o11 col7");
    boundCase(6, 3, 3, 1, "R4 o11 col6");
  endtask

  task automatic blockCase(input int px, input int py, input int k, input int bx, input int by,
                           input string req);
    int res, pl;
    clearAll(); putPiece(px, py, k, 1'b1); lightCell(bx, by);
    loadPiece(px, py, k);
    rotate(res, pl);
    chk(req, res, 2);
    chk({req, " no write"}, wrCount, 0);
    chkField({req, " field kept"});
  endtask

  task automatic testVacancy();
    blockCase(4, 4, 0, 4, 2, "R5 target p1 lit");
    blockCase(4, 4, 0, 4, 5, "R5 target p4 lit");
  endtask

  task automatic testObstacle();
    blockCase(4, 4, 0, 3, 2, "R6 swept cell o00");
    blockCase(4, 4, 0, 5, 5, "R6 swept corner o00");
    blockCase(4, 4, 1, 3, 5, "R6 swept cell o01");
  endtask

  task automatic testUnrelated();
    int res, pl;
    clearAll(); putPiece(4, 4, 0, 1'b1);
    lightCell(6, 6); lightCell(1, 1); lightCell(4, 1); lightCell(2, 5);
    loadPiece(4, 4, 0);
    rotate(res, pl);
    chk("R7 unrelated lit cells", res, 1);
    chk("R7 write count", wrCount, 6);
    expPiece(4, 4, 0, 1'b0); expPiece(4, 4, 1, 1'b1);
    chkField("R7 field after turn");
  endtask

  task automatic testBusyIgnore();
    int n = 0;
    int dones = 0;
    clearAll(); putPiece(4, 4, 0, 1'b1);
    loadPiece(4, 4, 0);
    wrCount = 0;
    @(negedge clk); rotReq = 1'b1;
    @(negedge clk); rotReq = 1'b0;
    repeat (3) @(negedge clk);
    rotReq = 1'b1; loadEn = 1'b1; loadX = 3'd1; loadY = 3'd1; loadOrient = 2'd3;
    @(negedge clk);
    rotReq = 1'b0; loadEn = 1'b0;
    while (n < 80) begin
      if (done) dones++;
      @(negedge clk); n++;
    end
    chk("R11 one rotation while busy", dones, 1);
    chk("R11 orient after busy pulses", int'(orient), 1);
    expPiece(4, 4, 0, 1'b0); expPiece(4, 4, 1, 1'b1);
    chkField("R11 field after busy pulses");
    // load and rotate together while idle: load taken, no rotation
    wrCount = 0;
    @(negedge clk);
    rotReq = 1'b1; loadEn = 1'b1; loadX = 3'd4; loadY = 3'd4; loadOrient = 2'd2;
    @(negedge clk);
    rotReq = 1'b0; loadEn = 1'b0;
    chk("R11 load beats rotate busy", int'(busy), 0);
    repeat (30) @(negedge clk);
    chk("R11 load beats rotate orient", int'(orient), 2);
    chk("R11 load beats rotate writes", wrCount, 0);
  endtask

  initial begin
    clearAll();
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLoad();
    testBasic();
    fullCycleField();
    testBounds();
    testVacancy();
    testObstacle();
    testUnrelated();
    testBusyIgnore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule